// File: doc/BRIEF.md
# Parallel Flash Command Lane Formatter

This block prepares command traffic for a bank of parallel flash chips that share one data bus side by side. From a command byte, a logical command offset and the bank geometry (bus width, interleave count, chip device width), it builds the bus word that puts the command into every chip's lane. It also builds the byte address on the bus where that word must be written. The same request also folds a raw readback word from the bus into one per-chip status value, so polling code sees a single chip-sized result.

Geometry arrives as three 2-bit log2 selectors on every request, so one instance serves any bank shape. An optional byte swap turns a 16- or 32-bit chip pattern into the opposite byte order. A request is one `req_valid` cycle. The results come back registered on the next cycle with `rsp_valid`. A two-state controller watches for impossible geometry. In READY, a request with illegal geometry takes the transition TRIP into FAULT. Any other request takes STAY, which keeps READY. FAULT has the single transition HOLD back to itself and leaves only through reset. While in FAULT the block still answers requests.

Top module: `flash_lane_formatter`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `rsp_valid`, `geom_fault`, `cmd_word`, `bus_addr` and `merged_status` are all zero.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. The three data outputs change only in those cycles and otherwise hold their last value.
- R3: Selector encodings are log2 values. `bus_sel` gives a bus width of 1, 2, 4 or 8 bytes, and `ilv_sel` gives 1, 2, 4 or 8 chips. `dev_sel` gives a chip width of 1, 2 or 4 bytes for codes 0, 1 and 2. Code 3 of `dev_sel` is illegal. A geometry is legal only if `dev_sel` is not 3 and the chip mode width (bus bytes divided by interleave) is 1, 2 or 4 bytes.
- R4: A request with illegal geometry returns zero on `cmd_word`, `bus_addr` and `merged_status`, and `geom_fault` is high in the same cycle as its `rsp_valid`.
- R5: Once high, `geom_fault` stays high until reset. Legal requests made afterwards are still answered correctly.
- R6: `bus_addr` equals `cmd_ofs` shifted left by `dev_sel + ilv_sel` (the offset times device bytes times interleave), truncated to the address width.
- R7: Suppose the device bytes times the interleave exceed the bus bytes and `cmd_ofs[7:0]` is 0xAA. Then `bus_addr` is also OR-ed with (device bytes / 2) times the interleave.
- R8: Without swap, every chip lane holds the command byte in its lowest byte and zeros elsewhere. Lane i occupies bus bytes i*M to i*M+M-1, where M is the chip mode width. Bus bits above the bus width are zero.
- R9: With `swap_en` high and a chip mode of 2 or 4 bytes, each lane holds the command byte in its highest byte. For a 1-byte mode, `swap_en` has no effect.
- R10: `merged_status` holds, in its low M bytes, the bitwise OR of all lanes of `raw_rd` within the bus width. Raw bits above the bus width are ignored, and status bits above M bytes are zero.
- R11: With `swap_en` high and a chip mode of 2 or 4 bytes, the M bytes of the merged status come out in reversed byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| bus_sel | input | 2 | log2 of bus width in bytes |
| ilv_sel | input | 2 | log2 of chips interleaved on the bus |
| dev_sel | input | 2 | log2 of chip device width in bytes (3 illegal) |
| swap_en | input | 1 | Reverse byte order inside 2- and 4-byte chip lanes |
| cmd_byte | input | 8 | Command byte to replicate |
| cmd_ofs | input | 32 | Logical command offset |
| raw_rd | input | 64 | Raw bus readback word to merge |
| rsp_valid | output | 1 | Results valid, one cycle after a request |
| cmd_word | output | 64 | Replicated command bus word |
| bus_addr | output | 32 | Scaled byte address on the bus |
| merged_status | output | 32 | Per-chip merged status |
| geom_fault | output | 1 | Sticky illegal-geometry flag |

## Verification
The bench aims at the odd-address tweak. It drives offsets ending in 0xAA with wide devices on narrow buses, where a design that drops the tweak returns 0x154 instead of 0x155. It also drives offsets ending in 0xAA on matched buses, where a design that applies the tweak too widely sets a stray low address bit. Eight-chip banks on a 64-bit bus stress the cascade. A design that skips one shift step leaves empty command lanes, or leaves status lanes un-merged. Illegal geometry is checked for zeroed outputs and a flag that never clears, and later legal requests are still checked. Swapped 2- and 4-byte modes catch a byte order inverted in only one direction or applied to 1-byte chips.

// File: rtl/flash_lane_pkg.sv
package flash_lane_pkg;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_FAULT = 1'b1
    } fmt_state_e;

    // Decoded bank geometry, all widths in log2 form.
    typedef struct packed {
        logic       ok;        // geometry is legal
        logic [1:0] bus_log;   // bus bytes
        logic [1:0] il_log;    // chips on the bus
        logic [1:0] dev_log;   // device bytes
        logic [1:0] cm_log;    // per-chip mode bytes
        logic [1:0] cpw_log;   // chips per machine word
        logic [1:0] wpb_log;   // machine words per bus
        logic [2:0] scale_log; // address scale
        logic       widen;     // device*interleave wider than bus
    } geom_t;

    localparam int CPW_STEPS = 3;

    function automatic logic [31:0] chip_mask(input logic [1:0] cm_log);
        logic [31:0] m;
        unique case (cm_log)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] chip_swap(input logic [31:0] v, input logic [1:0] cm_log);
        logic [31:0] r;
        unique case (cm_log)
            2'd0:    r = {24'h0, v[7:0]};
            2'd1:    r = {16'h0, v[7:0], v[15:8]};
            default: r = {v[7:0], v[15:8], v[23:16], v[31:24]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/geom_decode.sv
module geom_decode
    import flash_lane_pkg::*;
#(
    parameter int BUS_MAX_LOG = 3,
    parameter int WORD_LOG    = 2
) (
    input  logic [1:0] bus_sel,
    input  logic [1:0] ilv_sel,
    input  logic [1:0] dev_sel,
    output geom_t      geom
);

    always_comb begin
        int b;
        int i;
        int d;
        int wl;
        int cm;
        int cpw;
        int wpb;
        logic legal;

        b   = int'(bus_sel);
        i   = int'(ilv_sel);
        d   = int'(dev_sel);
        wl  = (b < WORD_LOG) ? b : WORD_LOG;
        cm  = b - i;
        cpw = wl + i - b;
        wpb = b - wl;

        legal = (d != 3) && (b <= BUS_MAX_LOG) && (cm >= 0) && (cm <= 2)
                && (cpw >= 0) && (cpw <= CPW_STEPS);

        geom.ok        = legal;
        geom.bus_log   = bus_sel;
        geom.il_log    = ilv_sel;
        geom.dev_log   = dev_sel;
        geom.cm_log    = legal ? 2'(cm) : 2'd0;
        geom.cpw_log   = legal ? 2'(cpw) : 2'd0;
        geom.wpb_log   = legal ? 2'(wpb) : 2'd0;
        geom.scale_log = 3'(d + i);
        geom.widen     = (d + i) > b;
    end

endmodule

// File: rtl/cmd_replicator.sv
module cmd_replicator
    import flash_lane_pkg::*;
#(
    parameter int BUS_MAX_LOG = 3,
    parameter int WORD_LOG    = 2
) (
    input  geom_t                          geom,
    input  logic                           swap_en,
    input  logic [7:0]                     cmd_byte,
    output logic [(8<<BUS_MAX_LOG)-1:0]    cmd_word
);

    localparam int WORD_BITS = 8 << WORD_LOG;
    localparam int MAX_WPB   = 1 << (BUS_MAX_LOG - WORD_LOG);

    logic [31:0]          lane_pat;
    logic [WORD_BITS-1:0] word_acc;

    // Single-chip pattern, placed per chip mode and byte order.
    always_comb begin
        lane_pat = {24'h0, cmd_byte};
        if (swap_en) begin
            unique case (geom.cm_log)
                2'd1:    lane_pat = {16'h0, cmd_byte, 8'h0};
                2'd2:    lane_pat = {cmd_byte, 24'h0};
                default: lane_pat = {24'h0, cmd_byte};
            endcase
        end
    end

    // Cascade from the widest step down: lane 0 -> every lane of a word.
    always_comb begin
        word_acc = WORD_BITS'(lane_pat);
        for (int s = CPW_STEPS - 1; s >= 0; s--) begin
            if (int'(geom.cpw_log) > s) begin
                word_acc = word_acc | (word_acc << (8 << (int'(geom.cm_log) + s)));
            end
        end
    end

    // Copy the word into each machine word that the bus spans.
    for (genvar w = 0; w < MAX_WPB; w++) begin : g_word
        assign cmd_word[w*WORD_BITS +: WORD_BITS] =
            (geom.ok && (32'(w) < (32'd1 << geom.wpb_log))) ? word_acc : '0;
    end

endmodule

// File: rtl/addr_scaler.sv
module addr_scaler
    import flash_lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  geom_t              geom,
    input  logic [ADDR_W-1:0]  cmd_ofs,
    output logic [ADDR_W-1:0]  bus_addr
);

    logic tweak_hit;

    assign tweak_hit = geom.widen && (cmd_ofs[7:0] == 8'hAA) && (geom.dev_log != 2'd0);

    always_comb begin
        bus_addr = cmd_ofs << geom.scale_log;
        if (tweak_hit) begin
            bus_addr = bus_addr |
                (ADDR_W'(1) << (int'(geom.dev_log) - 1 + int'(geom.il_log)));
        end
        if (!geom.ok) begin
            bus_addr = '0;
        end
    end

endmodule

// File: rtl/status_merger.sv
module status_merger
    import flash_lane_pkg::*;
#(
    parameter int BUS_MAX_LOG = 3,
    parameter int WORD_LOG    = 2
) (
    input  geom_t                        geom,
    input  logic                         swap_en,
    input  logic [(8<<BUS_MAX_LOG)-1:0]  raw_rd,
    output logic [31:0]                  merged_status
);

    localparam int BUS_BYTES = 1 << BUS_MAX_LOG;
    localparam int WORD_BITS = 8 << WORD_LOG;
    localparam int MAX_WPB   = 1 << (BUS_MAX_LOG - WORD_LOG);

    logic [BUS_BYTES*8-1:0] kept;
    logic [WORD_BITS-1:0]   fold;
    logic [31:0]            chip_val;

    // Drop bytes beyond the configured bus width.
    for (genvar b = 0; b < BUS_BYTES; b++) begin : g_keep
        assign kept[b*8 +: 8] =
            (32'(b) < (32'd1 << geom.bus_log)) ? raw_rd[b*8 +: 8] : 8'h00;
    end

    // OR machine words together, then collapse chip lanes toward lane 0.
    always_comb begin
        fold = '0;
        for (int w = 0; w < MAX_WPB; w++) begin
            fold = fold | kept[w*WORD_BITS +: WORD_BITS];
        end
        for (int s = 0; s < CPW_STEPS; s++) begin
            if (int'(geom.cpw_log) > s) begin
                fold = fold | (fold >> (8 << (int'(geom.cm_log) + s)));
            end
        end
    end

    always_comb begin
        chip_val = 32'(fold) & chip_mask(geom.cm_log);
        if (swap_en) begin
            chip_val = chip_swap(chip_val, geom.cm_log);
        end
        merged_status = geom.ok ? chip_val : 32'h0;
    end

endmodule

// File: rtl/flash_lane_formatter.sv
module flash_lane_formatter
    import flash_lane_pkg::*;
#(
    parameter int BUS_MAX_LOG = 3,
    parameter int WORD_LOG    = 2,
    parameter int ADDR_W      = 32,
    localparam int BUS_BITS   = 8 << BUS_MAX_LOG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           bus_sel,
    input  logic [1:0]           ilv_sel,
    input  logic [1:0]           dev_sel,
    input  logic                 swap_en,
    input  logic [7:0]           cmd_byte,
    input  logic [ADDR_W-1:0]    cmd_ofs,
    input  logic [BUS_BITS-1:0]  raw_rd,
    output logic                 rsp_valid,
    output logic [BUS_BITS-1:0]  cmd_word,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [31:0]          merged_status,
    output logic                 geom_fault
);

    geom_t                geom;
    logic [BUS_BITS-1:0]  word_nx;
    logic [ADDR_W-1:0]    addr_nx;
    logic [31:0]          stat_nx;
    fmt_state_e           state_q;
    fmt_state_e           state_d;

    geom_decode #(.BUS_MAX_LOG(BUS_MAX_LOG), .WORD_LOG(WORD_LOG)) u_geom (
        .bus_sel (bus_sel),
        .ilv_sel (ilv_sel),
        .dev_sel (dev_sel),
        .geom    (geom)
    );

    cmd_replicator #(.BUS_MAX_LOG(BUS_MAX_LOG), .WORD_LOG(WORD_LOG)) u_cmd (
        .geom     (geom),
        .swap_en  (swap_en),
        .cmd_byte (cmd_byte),
        .cmd_word (word_nx)
    );

    addr_scaler #(.ADDR_W(ADDR_W)) u_addr (
        .geom     (geom),
        .cmd_ofs  (cmd_ofs),
        .bus_addr (addr_nx)
    );

    status_merger #(.BUS_MAX_LOG(BUS_MAX_LOG), .WORD_LOG(WORD_LOG)) u_stat (
        .geom          (geom),
        .swap_en       (swap_en),
        .raw_rd        (raw_rd),
        .merged_status (stat_nx)
    );

    // Next-state logic: TRIP, STAY, HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (req_valid && !geom.ok) state_d = ST_FAULT;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    assign geom_fault = (state_q == ST_FAULT);

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            cmd_word      <= '0;
            bus_addr      <= '0;
            merged_status <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                cmd_word      <= word_nx;
                bus_addr      <= addr_nx;
                merged_status <= stat_nx;
            end
        end
    end

    // R2: response strobe tracks the request one cycle later
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(cmd_word) && $stable(bus_addr) && $stable(merged_status)));
    // R4: illegal geometry zeroes the data and raises the flag
    a_r4_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !geom.ok) |=> (cmd_word == '0 && bus_addr == '0
                                     && merged_status == 32'h0 && geom_fault));
    // R5: flag is sticky
    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        geom_fault |=> geom_fault);
    // R6: address has no bits below the scale when the tweak cannot apply
    a_r6_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && geom.ok && cmd_ofs[7:0] != 8'hAA) |=>
        (((bus_addr >> $past(geom.scale_log)) << $past(geom.scale_log)) == bus_addr));
    // R8: lane 0 low byte carries the command without swap
    a_r8_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && geom.ok && !swap_en) |=> (cmd_word[7:0] == $past(cmd_byte)));

endmodule

// File: tb/tb_flash_lane_formatter.sv
`timescale 1ns/1ps
module tb_flash_lane_formatter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  bus_sel = '0, ilv_sel = '0, dev_sel = '0;
    logic        swap_en = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [31:0] cmd_ofs = '0;
    logic [63:0] raw_rd = '0;
    logic        rsp_valid, geom_fault;
    logic [63:0] cmd_word;
    logic [31:0] bus_addr, merged_status;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // reference state
    logic        e_valid = 0, e_fault = 0;
    logic [63:0] e_word = '0;
    logic [31:0] e_addr = '0, e_stat = '0;
    string       t_word = "R1", t_addr = "R1", t_stat = "R1", t_fault = "R1";

    always #4 clk = ~clk;

    flash_lane_formatter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_sel(bus_sel),
        .ilv_sel(ilv_sel), .dev_sel(dev_sel), .swap_en(swap_en), .cmd_byte(cmd_byte),
        .cmd_ofs(cmd_ofs), .raw_rd(raw_rd), .rsp_valid(rsp_valid), .cmd_word(cmd_word),
        .bus_addr(bus_addr), .merged_status(merged_status), .geom_fault(geom_fault)
    );

    function automatic void predict(
        input logic [1:0] bl, input logic [1:0] il, input logic [1:0] dl,
        input logic sw, input logic [7:0] c, input logic [31:0] o, input logic [63:0] raw,
        output logic ok, output logic [63:0] w, output logic [31:0] a,
        output logic [31:0] st, output logic tweak, output logic swp);
        int cm, n, bb, ib, db;
        logic [7:0] acc;
        bb = int'(bl); ib = int'(il); db = int'(dl);
        ok = (db != 3) && (bb >= ib) && (bb - ib <= 2);
        w = '0; a = '0; st = '0; tweak = 0; swp = 0;
        if (ok) begin
            cm = 1 << (bb - ib);
            n  = 1 << ib;
            swp = sw && (cm > 1);
            for (int i = 0; i < n; i++)
                for (int b = 0; b < cm; b++)
                    w[(i*cm+b)*8 +: 8] = (b == (swp ? cm-1 : 0)) ? c : 8'h00;
            a = o << (db + ib);
            tweak = ((1 << db) * n > (1 << bb)) && (o[7:0] == 8'hAA);
            if (tweak) a = a | 32'(((1 << db) >> 1) * n);
            for (int b = 0; b < cm; b++) begin
                acc = 8'h00;
                for (int i = 0; i < n; i++) acc = acc | raw[(i*cm+b)*8 +: 8];
                st[(swp ? cm-1-b : b)*8 +: 8] = acc;
            end
        end
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        logic ok, tw, sp;
        logic [63:0] w;
        logic [31:0] a, s;
        if (!rst_n) begin
            e_valid = 0; e_fault = 0; e_word = '0; e_addr = '0; e_stat = '0;
        end else begin
            e_valid = req_valid;
            if (req_valid) begin
                predict(bus_sel, ilv_sel, dev_sel, swap_en, cmd_byte, cmd_ofs, raw_rd,
                        ok, w, a, s, tw, sp);
                e_word = w; e_addr = a; e_stat = s;
                if (!ok) begin
                    e_fault = 1;
                    t_word = "R4"; t_addr = "R4"; t_stat = "R4"; t_fault = "R3 R4";
                end else begin
                    t_word = sp ? "R9" : "R8";
                    t_addr = tw ? "R7" : "R6";
                    t_stat = sp ? "R11" : "R10";
                    t_fault = "R5";
                end
            end
        end
    end

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        check64("R2", 64'(rsp_valid), 64'(e_valid));
        check64(t_fault, 64'(geom_fault), 64'(e_fault));
        check64(t_word, cmd_word, e_word);
        check64(t_addr, 64'(bus_addr), 64'(e_addr));
        check64(t_stat, 64'(merged_status), 64'(e_stat));
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic req(input logic [1:0] b, input logic [1:0] i, input logic [1:0] d,
                       input logic s, input logic [7:0] c, input logic [31:0] o,
                       input logic [63:0] r);
        @(negedge clk);
        req_valid = 1; bus_sel = b; ilv_sel = i; dev_sel = d;
        swap_en = s; cmd_byte = c; cmd_ofs = o; raw_rd = r;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        // R1: reset state observed by the per-cycle compare
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R8: 64-bit bus, two 32-bit lanes
        req(2'd3, 2'd1, 2'd2, 0, 8'h98, 32'h55, 64'h0000_0080_0000_0001);
        // R7: 16-bit device on 8-bit bus, offset 0xAA -> 0x155
        req(2'd0, 2'd0, 2'd1, 0, 8'hAA, 32'hAA, 64'h0);
        // R7: 32-bit device on 16-bit bus
        req(2'd1, 2'd0, 2'd2, 0, 8'h55, 32'h5AA, 64'hFFFF_FFFF_FFFF_1234);
        // R6: matched width, 0xAA offset gets no tweak
        req(2'd1, 2'd0, 2'd1, 0, 8'hF0, 32'hAA, 64'h0);
        // R9 R11: swapped 16-bit lanes
        req(2'd2, 2'd1, 2'd1, 1, 8'h90, 32'h2AA, 64'h0000_0000_8001_0280);
        // R9 R11: swapped 32-bit lane
        req(2'd2, 2'd0, 2'd2, 1, 8'h70, 32'h555, 64'h0000_0000_1122_3344);
        // R10: eight byte-wide chips, status OR
        req(2'd3, 2'd3, 2'd0, 1, 8'hFF, 32'h10, 64'h8001_0204_0810_2040);
        // R2: back-to-back requests
        @(negedge clk);
        req_valid = 1; bus_sel = 2'd3; ilv_sel = 2'd2; dev_sel = 2'd1; cmd_byte = 8'h98;
        @(negedge clk);
        cmd_byte = 8'h60; cmd_ofs = 32'h1AA;
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        // R3 R4: illegal device code, then illegal ratio
        req(2'd2, 2'd0, 2'd3, 0, 8'h98, 32'h55, 64'hFF);
        req(2'd0, 2'd1, 2'd0, 0, 8'h98, 32'h55, 64'hFF);
        // R5: legal request after the fault
        req(2'd1, 2'd1, 2'd0, 0, 8'hAA, 32'hAA, 64'h0000_0000_0000_0301);
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            req_valid = ($urandom % 3) != 0;
            bus_sel = 2'($urandom); ilv_sel = 2'($urandom); dev_sel = 2'($urandom);
            swap_en = 1'($urandom);
            cmd_byte = 8'($urandom);
            cmd_ofs = $urandom;
            if ($urandom % 2 == 0) cmd_ofs[7:0] = 8'hAA;
            raw_rd = {$urandom, $urandom};
        end
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule